// File: doc/BRIEF.md
# JTAG Chain Enumeration Engine

This block discovers the devices on a JTAG scan chain on its own. It generates TCK from the system clock and drives TMS and TDI. It samples TDO on each rising TCK edge and reads the chain's data-register path one device at a time. At the first bit returned for each device it decides what kind of register that device offers. A 0 means a one-bit bypass register. A 1 is the mandatory first bit of a 32-bit identification code. Each device found is written into a small identifier table that a reader port can access, and the device count is kept alongside.

TDI is held at a fixed fill pattern: seven ones followed by zeros. Once that pattern has travelled through every device it comes back on TDO. It then looks like an identifier whose 11-bit manufacturer field reads 0x3F. That value marks the end of the chain. A hard device limit stops a broken chain from keeping the engine busy forever, and a separate flag reports devices that did not fit in the table.

The engine is started with a single-cycle `start` pulse while the chain's TAP controllers sit in Run-Test/Idle. It leaves them in Run-Test/Idle when it finishes. The state machine has eight states:

- IDLE: waiting for `start`.
- ENTER: three TCK cycles that move the TAPs to Shift-DR.
- PROBE: samples one bit to classify the next device.
- MANUF: collects the 11-bit manufacturer field.
- REST: collects the remaining 20 bits of the identifier.
- LEAVE: three TCK cycles that move the TAPs back to Run-Test/Idle.
- TAIL: waits for TCK to fall.
- DONE: a single cycle that signals completion.

The transitions are:

- IDLE→ENTER on `start`.
- ENTER→PROBE after its third rising edge.
- PROBE→MANUF on a sampled 1.
- PROBE→PROBE on a sampled 0, which records a bypass device.
- PROBE→LEAVE on a sampled 0 that fills the last allowed device slot.
- MANUF→LEAVE when the manufacturer field equals the end code.
- MANUF→REST for any other manufacturer field.
- REST→PROBE after recording an identifier.
- REST→LEAVE after recording an identifier that fills the last allowed slot.
- LEAVE→TAIL after its third rising edge.
- TAIL→DONE on the falling TCK edge.
- DONE→IDLE.

Top module: `chain_scan_enum`

## Requirements
- R1: After reset `tck` and `tms` are 0, `busy` and `done` are 0, `dev_count` is 0, and `overflow` and `limit_hit` are 0.
- R2: After `start`, the first three rising TCK edges carry TMS = 1, 0, 0. This moves the TAPs from Run-Test/Idle to Shift-DR. TMS and TDI change only while TCK is low.
- R3: On the rising TCK edges made in Shift-DR, TDI carries 1 for the first seven edges and 0 for every edge after that.
- R4: A 0 sampled as the first bit of a device records that device as bypassed. Its table entry is 0xFFFFFFFF and the device count goes up by one.
- R5: A 1 sampled as the first bit of a device starts an identifier. The next 11 bits (least significant first) form the manufacturer field and the following 20 bits form the rest. The stored entry is (rest << 12) | (manufacturer << 1) | 1.
- R6: A manufacturer field equal to 0x3F ends enumeration. No device is recorded for that read and any further devices are not examined.
- R7: When the device count reaches MAX_DEVS, enumeration stops and `limit_hit` is set. The count never exceeds MAX_DEVS.
- R8: Devices found beyond TABLE_DEPTH are not stored but are still counted, and `overflow` is set.
- R9: On completion the last three rising TCK edges carry TMS = 1, 1, 0. This leaves the TAPs in Run-Test/Idle, and TCK is low whenever the engine is not busy.
- R10: `start` launches a run. `busy` is high for the whole run. `done` is high for exactly one cycle with the final count valid. A `start` pulse given while busy has no effect.
- R11: `rd_data` shows the table entry at `rd_addr`. Entry 0 belongs to the device nearest TDO, and later devices follow in chain order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse that launches enumeration |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| dev_count | output | $clog2(MAX_DEVS+1) | Number of devices found |
| overflow | output | 1 | More devices were found than the table holds |
| limit_hit | output | 1 | The hard device limit ended the run |
| rd_addr | input | $clog2(TABLE_DEPTH) | Table read index |
| rd_data | output | 32 | Table entry at `rd_addr` |
| tck | output | 1 | Test clock to the chain |
| tms | output | 1 | Test mode select to the chain |
| tdi | output | 1 | Test data into the chain |
| tdo | input | 1 | Test data back from the chain |

## Verification
The hardest outcomes to reach are the two early stops. The hard limit needs a chain longer than MAX_DEVS. The false end needs a real device whose manufacturer field happens to equal the end code.

The bench instantiates the engine with a small MAX_DEVS and a small table. It models a TAP-driven chain of up to sixteen devices whose capture values it chooses. One chain of thirteen bypass devices exceeds the limit and the table at the same time. Another chain places an identifier with manufacturer field 0x3F second, so the third device must never be read.

// File: rtl/chain_scan_pkg.sv
package chain_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_PROBE,
        ST_MANUF,
        ST_REST,
        ST_LEAVE,
        ST_TAIL,
        ST_DONE
    } scan_state_e;

    localparam int ID_W    = 32;
    localparam int MANUF_W = 11;
    localparam int REST_W  = 20;
    localparam int STEP_W  = 5;
    localparam logic [ID_W-1:0] BYPASS_MARK = '1;

endpackage

// File: rtl/chain_scan_tck_gen.sv
module chain_scan_tck_gen #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tck,
    output logic rise,
    output logic fall
);
    logic tck_q;

    generate
        if (HALF == 1) begin : g_fast
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   tck_q <= 1'b0;
                else if (!en) tck_q <= 1'b0;
                else          tck_q <= ~tck_q;
            end
            assign rise = en && !tck_q;
            assign fall = en && tck_q;
        end else begin : g_div
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt_q;
            logic          wrap;
            assign wrap = (cnt_q == CW'(HALF - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                    tck_q <= 1'b0;
                end else if (!en) begin
                    cnt_q <= '0;
                    tck_q <= 1'b0;
                end else if (wrap) begin
                    cnt_q <= '0;
                    tck_q <= ~tck_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            assign rise = en && wrap && !tck_q;
            assign fall = en && wrap && tck_q;
        end
    endgenerate

    assign tck = tck_q;
endmodule

// File: rtl/chain_scan_fill.sv
module chain_scan_fill #(
    parameter int ONES = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic load,
    output logic tdi
);
    localparam int CW = $clog2(ONES + 1);
    logic [CW-1:0] sent_q;
    logic          tdi_q;
    logic          more_ones;

    assign more_ones = (sent_q < CW'(ONES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q <= '0;
            tdi_q  <= 1'b1;
        end else if (clr) begin
            sent_q <= '0;
            tdi_q  <= 1'b1;
        end else begin
            if (step && more_ones) sent_q <= sent_q + 1'b1;
            if (load)              tdi_q  <= more_ones;
        end
    end

    assign tdi = tdi_q;
endmodule

// File: rtl/chain_scan_id_table.sv
module chain_scan_id_table #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/chain_scan_enum.sv
module chain_scan_enum
    import chain_scan_pkg::*;
#(
    parameter int MAX_DEVS    = 1024,
    parameter int TABLE_DEPTH = 16,
    parameter int TCK_HALF    = 4,
    parameter int FILL_ONES   = 7,
    localparam int CW = $clog2(MAX_DEVS + 1),
    localparam int AW = (TABLE_DEPTH > 1) ? $clog2(TABLE_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] dev_count,
    output logic          overflow,
    output logic          limit_hit,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          tck,
    output logic          tms,
    output logic          tdi,
    input  logic          tdo
);
    localparam logic [MANUF_W-1:0] END_CODE = MANUF_W'((1 << (FILL_ONES - 1)) - 1);

    scan_state_e         state_q, state_d;
    logic [STEP_W-1:0]   step_q;
    logic [CW-1:0]       idx_q;
    logic [MANUF_W-1:0]  man_q, man_full;
    logic [REST_W-2:0]   rest_q;
    logic [REST_W-1:0]   rest_full;
    logic                ovf_q, lim_q, tms_q, tms_plan;
    logic                rise, fall, gen_en, shifting;
    logic                rec_en, at_last, room, launch;
    logic [ID_W-1:0]     rec_word;

    assign man_full  = {tdo, man_q[MANUF_W-1:1]};
    assign rest_full = {tdo, rest_q};
    assign at_last   = (idx_q == CW'(MAX_DEVS - 1));
    assign room      = (idx_q < CW'(TABLE_DEPTH));
    assign launch    = (state_q == ST_IDLE) && start;

    // next state and record decision
    always_comb begin
        state_d  = state_q;
        rec_en   = 1'b0;
        rec_word = '0;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ENTER;
            ST_ENTER: if (rise && step_q == STEP_W'(2)) state_d = ST_PROBE;
            ST_PROBE: begin
                if (rise) begin
                    if (!tdo) begin
                        rec_en   = 1'b1;
                        rec_word = BYPASS_MARK;
                        state_d  = at_last ? ST_LEAVE : ST_PROBE;
                    end else begin
                        state_d = ST_MANUF;
                    end
                end
            end
            ST_MANUF: begin
                if (rise && step_q == STEP_W'(MANUF_W - 1))
                    state_d = (man_full == END_CODE) ? ST_LEAVE : ST_REST;
            end
            ST_REST: begin
                if (rise && step_q == STEP_W'(REST_W - 1)) begin
                    rec_en   = 1'b1;
                    rec_word = {rest_full, man_q, 1'b1};
                    state_d  = at_last ? ST_LEAVE : ST_PROBE;
                end
            end
            ST_LEAVE: if (rise && step_q == STEP_W'(2)) state_d = ST_TAIL;
            ST_TAIL:  if (fall) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // decoded outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        gen_en   = (state_q != ST_IDLE) && (state_q != ST_DONE);
        shifting = (state_q == ST_PROBE) || (state_q == ST_MANUF) || (state_q == ST_REST);
        unique case (state_q)
            ST_ENTER: tms_plan = (step_q == '0);
            ST_LEAVE: tms_plan = (step_q < STEP_W'(2));
            default:  tms_plan = 1'b0;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            idx_q   <= '0;
            man_q   <= '0;
            rest_q  <= '0;
            ovf_q   <= 1'b0;
            lim_q   <= 1'b0;
            tms_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) step_q <= '0;
            else if (rise)          step_q <= step_q + 1'b1;
            if (launch) begin
                idx_q <= '0;
                ovf_q <= 1'b0;
                lim_q <= 1'b0;
                tms_q <= 1'b1;
            end else if (fall) begin
                tms_q <= tms_plan;
            end
            if (rise && state_q == ST_MANUF) man_q  <= man_full;
            if (rise && state_q == ST_REST)  rest_q <= rest_full[REST_W-1:1];
            if (rec_en) begin
                idx_q <= idx_q + 1'b1;
                if (!room)  ovf_q <= 1'b1;
                if (at_last) lim_q <= 1'b1;
            end
        end
    end

    chain_scan_tck_gen #(.HALF(TCK_HALF)) u_tck (
        .clk (clk),
        .rst_n (rst_n),
        .en (gen_en),
        .tck (tck),
        .rise (rise),
        .fall (fall)
    );

    chain_scan_fill #(.ONES(FILL_ONES)) u_fill (
        .clk (clk),
        .rst_n (rst_n),
        .clr (launch),
        .step (rise && shifting),
        .load (fall),
        .tdi (tdi)
    );

    chain_scan_id_table #(.DEPTH(TABLE_DEPTH), .W(ID_W)) u_table (
        .clk (clk),
        .we (rec_en && room),
        .waddr (idx_q[AW-1:0]),
        .wdata (rec_word),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign dev_count = idx_q;
    assign overflow  = ovf_q;
    assign limit_hit = lim_q;
    assign tms       = tms_q;
endmodule

// File: rtl/chain_scan_checker.sv
module chain_scan_checker #(
    parameter int MAX_DEVS    = 1024,
    parameter int TABLE_DEPTH = 16,
    localparam int CW = $clog2(MAX_DEVS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tck,
    input logic          tms,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] dev_count,
    input logic          overflow,
    input logic          limit_hit
);
    assert_tms_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> !tck);

    assert_tck_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dev_count <= CW'(MAX_DEVS));

    assert_limit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |-> dev_count == CW'(MAX_DEVS));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> dev_count > CW'(TABLE_DEPTH));
endmodule

bind chain_scan_enum chain_scan_checker #(
    .MAX_DEVS(MAX_DEVS),
    .TABLE_DEPTH(TABLE_DEPTH)
) u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .tck (tck),
    .tms (tms),
    .busy (busy),
    .done (done),
    .dev_count (dev_count),
    .overflow (overflow),
    .limit_hit (limit_hit)
);

// File: tb/chain_scan_enum_bench.sv
module chain_scan_enum_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXD  = 12;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(MAXD + 1);
    localparam int AW    = $clog2(DEPTH);
    localparam int CHAIN_MAX = 640;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, overflow, limit_hit, tck, tms, tdi, tdo;
    logic [CW-1:0] dev_count;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int done_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_scan_enum #(.MAX_DEVS(MAXD), .TABLE_DEPTH(DEPTH), .TCK_HALF(2)) u_chain_scan_enum (
        .clk (clk), .rst_n (rst_n), .start (start), .busy (busy), .done (done),
        .dev_count (dev_count), .overflow (overflow), .limit_hit (limit_hit),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .tck (tck), .tms (tms), .tdi (tdi), .tdo (tdo)
    );

    // ---------------- chain model ----------------
    typedef enum {M_TLR, M_RTI, M_SDR, M_CDR, M_SHD, M_E1D, M_PDR, M_E2D, M_UDR, M_SIR} mst_e;
    mst_e mst = M_RTI;
    logic [CHAIN_MAX-1:0] chain = '0;
    logic [CHAIN_MAX-1:0] cap_vec = '0;
    int chain_len = 1;
    bit   dev_is_id [16];
    logic [31:0] dev_id [16];
    int ndev = 0;
    bit tms_log[$];
    bit tdi_log[$];

    assign tdo = chain[0];

    always @(posedge tck) begin
        tms_log.push_back(tms);
        if (mst == M_SHD) tdi_log.push_back(tdi);
        if (mst == M_CDR) chain = cap_vec;
        else if (mst == M_SHD)
            for (int i = 0; i < CHAIN_MAX - 1; i++)
                chain[i] = (i == chain_len - 1) ? tdi : chain[i+1];
        case (mst)
            M_TLR: mst = tms ? M_TLR : M_RTI;
            M_RTI: mst = tms ? M_SDR : M_RTI;
            M_SDR: mst = tms ? M_SIR : M_CDR;
            M_CDR: mst = tms ? M_E1D : M_SHD;
            M_SHD: mst = tms ? M_E1D : M_SHD;
            M_E1D: mst = tms ? M_UDR : M_PDR;
            M_PDR: mst = tms ? M_E2D : M_PDR;
            M_E2D: mst = tms ? M_UDR : M_SHD;
            M_UDR: mst = tms ? M_SDR : M_RTI;
            M_SIR: mst = M_TLR;
            default: mst = M_TLR;
        endcase
    end

    always @(posedge clk) if (done) done_seen++;

    // ---------------- scoreboard ----------------
    logic [31:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // monitor: compares table contents with expected items after each run
    initial begin
        forever begin
            @(posedge done);
            @(negedge clk);
            for (int i = 0; exp_q.size() > 0; i++) begin
                logic [31:0] e;
                rd_addr = AW'(i);
                #1;
                e = exp_q.pop_front();
                chk(rd_data === e, "R11", $sformatf("table entry %0d (R4/R5)", i), rd_data, e);
            end
        end
    end

    task automatic clear_chain();
        ndev = 0;
    endtask

    task automatic add_dev(input bit is_id, input logic [31:0] id);
        dev_is_id[ndev] = is_id;
        dev_id[ndev] = id;
        ndev++;
    endtask

    // driver: builds the chain, pushes expectations, runs the engine
    task automatic run_case(input string name);
        int pos;
        int cnt;
        bit stop;
        int base_done;
        int n;
        bit ok;
        logic [31:0] ecount;
        logic exp_lim, exp_ovf;
        cap_vec = '0;
        pos = 0;
        for (int d = 0; d < ndev; d++) begin
            if (dev_is_id[d]) begin
                cap_vec[pos +: 32] = dev_id[d];
                pos += 32;
            end else begin
                cap_vec[pos] = 1'b0;
                pos += 1;
            end
        end
        chain_len = pos;
        cnt = 0;
        stop = 0;
        for (int d = 0; d < ndev && !stop; d++) begin
            if (cnt == MAXD) stop = 1;
            else if (!dev_is_id[d]) begin
                if (cnt < DEPTH) exp_q.push_back(32'hFFFF_FFFF);
                cnt++;
            end else if (((dev_id[d] >> 1) & 32'h7FF) == 32'h3F) stop = 1;
            else begin
                if (cnt < DEPTH) exp_q.push_back(dev_id[d]);
                cnt++;
            end
        end
        ecount  = 32'(cnt);
        exp_lim = (cnt == MAXD);
        exp_ovf = (cnt > DEPTH);
        tms_log.delete();
        tdi_log.delete();
        mst = M_RTI;
        base_done = done_seen;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy === 1'b1, "R10", {name, " busy during run"}, 32'(busy), 1);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (done !== 1'b1 && n < 50000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, "R10", {name, " done reached"}, 32'(done), 1);
        chk(32'(dev_count) == ecount, "R4", {name, " device count (R5/R6/R7)"}, 32'(dev_count), ecount);
        chk(limit_hit === exp_lim, "R7", {name, " limit flag"}, 32'(limit_hit), 32'(exp_lim));
        chk(overflow === exp_ovf, "R8", {name, " overflow flag"}, 32'(overflow), 32'(exp_ovf));
        n = 0;
        while (exp_q.size() > 0 && n < 1000) begin
            @(negedge clk);
            n++;
        end
        repeat (40) @(negedge clk);
        chk(busy === 1'b0 && tck === 1'b0, "R9", {name, " idle with tck low"}, {30'd0, busy, tck}, 0);
        chk(done_seen == base_done + 1, "R10", {name, " one done pulse, restart ignored"},
            32'(done_seen - base_done), 1);
        chk(mst == M_RTI, "R9", {name, " chain back in Run-Test/Idle"}, 32'(mst), 32'(M_RTI));
        ok = tms_log.size() >= 6 && tms_log[0] == 1 && tms_log[1] == 0 && tms_log[2] == 0;
        chk(ok, "R2", {name, " entry TMS 1,0,0"}, 32'(tms_log.size()), 6);
        n = tms_log.size();
        ok = n >= 6 && tms_log[n-3] == 1 && tms_log[n-2] == 1 && tms_log[n-1] == 0;
        chk(ok, "R9", {name, " exit TMS 1,1,0"}, 32'(n), 6);
        ok = 1;
        for (int i = 0; i < tdi_log.size(); i++)
            if (tdi_log[i] != (i < 7)) ok = 0;
        chk(ok, "R3", {name, " TDI fill 7 ones then zeros"}, 32'(tdi_log.size()), 32'(tdi_log.size()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tck === 1'b0 && tms === 1'b0, "R1", "tck/tms at reset", {30'd0, tck, tms}, 0);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset", {30'd0, busy, done}, 0);
        chk(dev_count === '0 && overflow === 1'b0 && limit_hit === 1'b0, "R1", "count/flags at reset",
            {dev_count, overflow, limit_hit}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // mixed chain
        clear_chain();
        add_dev(1, 32'h1234_5679);
        add_dev(0, 32'h0);
        add_dev(1, 32'h8765_4321);
        run_case("mixed");

        // more devices than table entries
        clear_chain();
        add_dev(1, 32'h0ABC_D00F);
        add_dev(0, 32'h0);
        add_dev(1, 32'hDEAD_BEEF);
        add_dev(0, 32'h0);
        add_dev(0, 32'h0);
        add_dev(1, 32'h5555_AAAB);
        run_case("overflow");

        // broken chain longer than the hard limit
        clear_chain();
        for (int i = 0; i < 13; i++) add_dev(0, 32'h0);
        run_case("limit");

        // device whose manufacturer field equals the end code (R6)
        clear_chain();
        add_dev(0, 32'h0);
        add_dev(1, 32'h0000_107F);
        add_dev(1, 32'h1234_5679);
        run_case("endcode");

        finish_up();
    end
endmodule